// File: doc/BRIEF.md
# CIC Decimation Filter

This block is a multiplier-free low-pass filter that lowers the sample rate of a signed data stream by an integer factor R. Samples arrive with a valid strobe on the processing clock. A chain of N running-sum stages runs at the input rate. A rate reducer then keeps one sample in every R accepted. A chain of N difference stages, each with a differential delay of D output samples, runs only on those kept samples.

Every register carries the full worst-case word, so the output is exact with no rounding or truncation. The processing clock is never divided. The reduced output rate is carried by a one-cycle enable strobe inside the block and by a valid strobe on the output. Gaps in the input strobe are allowed at any point. The overall response equals that of a FIR filter formed by convolving N rectangular windows, each R·D samples long. The DC gain is (R·D)^N.

Top module: `cic_decim`

## Requirements
- R1: While rst_ni is low and right after it rises, valid_o is 0 and data_o is 0; all running sums, difference stages, delay lines and the sample counter are cleared, so the first output after reset comes after R freshly accepted samples.
- R2: data_o is IN_W + N·ceil(log2(R·D)) bits wide, and every internal stage uses that same width.
- R3: Running-sum stage 1 adds the sign-extended data_i on each cycle with valid_i high. Stage k>1 adds the value that stage k-1 held before that same edge. All sums wrap in two's complement, and no sum changes on a cycle with valid_i low.
- R4: If the R-th, 2R-th, 3R-th ... accepted sample since reset is taken at clock edge k, then valid_o is high from edge k+1 to edge k+2. valid_o is low at all other times.
- R5: On each output tick, difference stage 1 takes the last running sum as updated by that R-th sample. Stage k>1 takes the value stage k-1 held before the tick. Each stage outputs its input minus the input it received D ticks earlier (zero before that). A stage does not change between ticks.
- R6: With data_i held at a constant c, data_o settles to c·(R·D)^N after the transient, including at the extreme input values.
- R7: data_i on cycles with valid_i low has no effect, and idle cycles between accepted samples do not change any output value.
- R8: Asserting rst_ni in the middle of a stream discards all partial state. Later outputs match a filter started fresh at the release of reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Processing clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input sample strobe |
| data_i | input | IN_W | Signed input sample |
| valid_o | output | 1 | Output sample strobe, one cycle per R accepted samples |
| data_o | output | IN_W+N·ceil(log2(R·D)) | Signed full-precision output sample |

## Verification
The assertions take for granted that valid_i and data_i are stable around the rising edge and are never X while reset is released. They also assume nothing sits between the block and its source, so every cycle with valid_i high is an accepted sample. The stimulus changes inputs only on the falling edge. It mixes back-to-back samples with random idle gaps of up to two cycles, and it scrambles data_i on idle cycles. Reset is applied mid-stream and only on a falling edge, so the asynchronous clear never coincides with a sampling edge.

// File: rtl/cic_pkg.sv
package cic_pkg;
  // worst-case bit growth through N integrator/comb pairs
  function automatic int growth(input int n, input int r, input int d);
    return n * $clog2(r * d);
  endfunction
endpackage

// File: rtl/cic_integ.sv
module cic_integ #(
  parameter int W = 28
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                en_i,
  input  logic signed [W-1:0] din_i,
  output logic signed [W-1:0] acc_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   acc_o <= '0;
    else if (en_i) acc_o <= acc_o + din_i;  // wraps; harmless by design
  end

  assert_integ_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(acc_o));
endmodule

// File: rtl/cic_comb.sv
module cic_comb #(
  parameter int W = 28,
  parameter int D = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                en_i,
  input  logic signed [W-1:0] din_i,
  output logic signed [W-1:0] dout_o
);
  logic signed [W-1:0] dly_q [D];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dout_o <= '0;
      for (int i = 0; i < D; i++) dly_q[i] <= '0;
    end else if (en_i) begin
      dout_o   <= din_i - dly_q[D-1];
      dly_q[0] <= din_i;
      for (int i = 1; i < D; i++) dly_q[i] <= dly_q[i-1];
    end
  end

  assert_comb_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(dout_o));
endmodule

// File: rtl/cic_rate_ctr.sv
module cic_rate_ctr #(
  parameter int R = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  output logic tick_o
);
  localparam int CW = (R > 1) ? $clog2(R) : 1;
  localparam logic [CW-1:0] LAST = CW'(R - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = valid_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (tick_o)  cnt_q <= '0;
    else if (valid_i) cnt_q <= cnt_q + 1'b1;
  end

  assert_cnt_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
  assert_cnt_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(cnt_q));
endmodule

// File: rtl/cic_decim.sv
module cic_decim #(
  parameter  int IN_W  = 16,
  parameter  int N     = 3,
  parameter  int R     = 8,
  parameter  int D     = 2,
  localparam int OUT_W = IN_W + cic_pkg::growth(N, R, D)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    valid_i,
  input  logic signed [IN_W-1:0]  data_i,
  output logic                    valid_o,
  output logic signed [OUT_W-1:0] data_o
);
  logic signed [OUT_W-1:0] integ_v [N+1];
  logic signed [OUT_W-1:0] comb_v  [N+1];
  logic tick, ce_q;

  assign integ_v[0] = OUT_W'(data_i);

  for (genvar g = 0; g < N; g++) begin : g_integ
    cic_integ #(.W(OUT_W)) u_integ (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .en_i  (valid_i),
      .din_i (integ_v[g]),
      .acc_o (integ_v[g+1])
    );
  end

  cic_rate_ctr #(.R(R)) u_rate (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(valid_i),
    .tick_o (tick)
  );

  // comb chain reads the last integrator one cycle after the R-th sample lands
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ce_q    <= 1'b0;
      valid_o <= 1'b0;
    end else begin
      ce_q    <= tick;
      valid_o <= ce_q;
    end
  end

  assign comb_v[0] = integ_v[N];

  for (genvar g = 0; g < N; g++) begin : g_comb
    cic_comb #(.W(OUT_W), .D(D)) u_comb (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .en_i  (ce_q),
      .din_i (comb_v[g]),
      .dout_o(comb_v[g+1])
    );
  end

  assign data_o = comb_v[N];

  assert_out_after_in_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(valid_i, 2));
  if (R > 1) begin : g_pulse_chk
    assert_valid_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_o |=> !valid_o);
  end
  assert_out_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |=> $stable(data_o) || valid_o);
endmodule

// File: tb/cic_decim_test.sv
module cic_decim_test;
  localparam int IN_W  = 16;
  localparam int N     = 3;
  localparam int R     = 8;
  localparam int D     = 2;
  localparam int ACC_W = IN_W + N * $clog2(R * D);

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic valid_i = 1'b0;
  logic signed [IN_W-1:0]  data_i = '0;
  logic                    valid_o;
  logic signed [ACC_W-1:0] data_o;

  always #2.5 clk = ~clk;

  cic_decim #(.IN_W(IN_W), .N(N), .R(R), .D(D)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .data_i(data_i),
    .valid_o(valid_o), .data_o(data_o)
  );

  int tests = 0, fails = 0, cyc = 0;
  bit done = 1'b0;

  // bench reference state
  logic signed [ACC_W-1:0] m_int [N];
  logic signed [ACC_W-1:0] m_cmb [N];
  logic signed [ACC_W-1:0] m_dly [N][D];
  int m_cnt;
  logic signed [ACC_W-1:0] exp_val [$];
  int exp_due [$];
  logic signed [ACC_W-1:0] last_out;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic model_clear();
    for (int k = 0; k < N; k++) begin
      m_int[k] = '0; m_cmb[k] = '0;
      for (int j = 0; j < D; j++) m_dly[k][j] = '0;
    end
    m_cnt = 0;
    exp_val.delete(); exp_due.delete();
  endtask

  task automatic model_step(input logic signed [IN_W-1:0] x);
    logic signed [ACC_W-1:0] in_v;
    for (int k = N - 1; k >= 0; k--)
      m_int[k] = m_int[k] + ((k == 0) ? ACC_W'(x) : m_int[k-1]);
    m_cnt++;
    if (m_cnt == R) begin
      m_cnt = 0;
      for (int k = N - 1; k >= 0; k--) begin
        in_v = (k == 0) ? m_int[N-1] : m_cmb[k-1];
        m_cmb[k] = in_v - m_dly[k][D-1];
        for (int j = D - 1; j > 0; j--) m_dly[k][j] = m_dly[k][j-1];
        m_dly[k][0] = in_v;
      end
      exp_val.push_back(m_cmb[N-1]);
      exp_due.push_back(cyc + 2);
    end
  endtask

  task automatic drive(input logic signed [IN_W-1:0] x, input bit v);
    @(negedge clk);
    valid_i = v;
    data_i  = x;
    if (v) model_step(x);
  endtask

  // output monitor: timing (R4) and value (R3, R5, R7)
  always @(negedge clk) begin
    if (rst_ni && !done) begin
      if (valid_o) begin
        last_out = data_o;
        if (exp_due.size() == 0) check(1'b0, "R4 unexpected valid_o", 1, 0);
        else begin
          check(exp_due[0] == cyc, "R4 valid_o cycle", cyc, exp_due[0]);
          check(data_o == exp_val[0], "R5 output value", data_o, exp_val[0]);
          void'(exp_due.pop_front());
          void'(exp_val.pop_front());
        end
      end else if (exp_due.size() != 0 && exp_due[0] <= cyc) begin
        check(1'b0, "R4 missing valid_o", 0, 1);
        void'(exp_due.pop_front());
        void'(exp_val.pop_front());
      end
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0; valid_i = 1'b0;
    model_clear();
    repeat (3) @(negedge clk);
    check(valid_o == 1'b0, "R1 valid_o in reset", valid_o, 0);
    check(data_o == '0, "R1 data_o in reset", data_o, 0);
    rst_ni = 1'b1;
  endtask

  task automatic drain();
    repeat (6) drive('0, 1'b0);
    check(exp_due.size() == 0, "R4 outputs outstanding", exp_due.size(), 0);
  endtask

  task automatic dc_run(input logic signed [IN_W-1:0] c, input string tag);
    longint gain = 1;
    for (int k = 0; k < N; k++) gain *= R * D;
    for (int i = 0; i < R * 12; i++) drive(c, 1'b1);
    drive('0, 1'b0);
    repeat (3) drive(16'sh5a5a, 1'b0);
    check(last_out == ACC_W'(longint'(c) * gain), tag, last_out, longint'(c) * gain);
  endtask

  initial begin
    void'($urandom(32'h00c1_cdec));
    model_clear();
    last_out = '0;
    check($bits(data_o) == IN_W + N * $clog2(R * D), "R2 output width",
          $bits(data_o), IN_W + N * $clog2(R * D));
    do_reset();
    @(negedge clk);
    check(valid_o == 1'b0 && data_o == '0, "R1 after release", data_o, 0);

    // impulse: shape of the combined moving-average response
    drive(16'sd1, 1'b1);
    for (int i = 0; i < R * D * N + 3 * R; i++) drive('0, 1'b1);
    drain();

    // DC at extremes
    dc_run(16'sd32767, "R6 dc max");
    drain();
    do_reset();
    dc_run(-16'sd32768, "R6 dc min");
    drain();
    do_reset();
    dc_run(16'sd1234, "R6 dc mid");

    // random samples with gaps and scrambled idle data (R7)
    for (int i = 0; i < 2000; i++) begin
      for (int g = $urandom_range(0, 2); g > 0; g--) drive(IN_W'($urandom), 1'b0);
      drive(IN_W'($urandom), 1'b1);
    end
    drain();

    // reset mid-stream after a partial frame (R8)
    for (int i = 0; i < R / 2 + 3; i++) drive(IN_W'($urandom), 1'b1);
    do_reset();
    for (int i = 0; i < 400; i++) begin
      if ($urandom_range(0, 3) == 0) drive(IN_W'($urandom), 1'b0);
      drive(IN_W'($urandom), 1'b1);
    end
    drain();

    // back-to-back full-scale alternating pattern (R3 wrap-around)
    for (int i = 0; i < 300; i++) drive((i % 2) ? -16'sd32768 : 16'sd32767, 1'b1);
    drain();

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule